// File: doc/BRIEF.md
# Wide-to-Narrow Write Data Streamer

This block takes wide elements from a local scratchpad and sends each one as a series of narrower beats on an AXI4-style write-data channel. A command gives the scratchpad start address, the destination address, the number of elements and the burst length. For each command the block issues one write-address request. Once that request is accepted, it sends the beats under a valid/ready handshake.

Each element is split into sub-blocks and sent lowest sub-block first. Between two elements the block spends exactly one cycle loading the next element from the scratchpad. Once every element has gone out, any beats left in the burst are sent as all-zero pad beats. The last beat carries the last flag, and a one-cycle done pulse follows it.

The sub-block select, the scratchpad read pointer and the column and beat counters all move only when a beat is accepted. A slave may therefore drop ready on any beat, including the high half of an element, and the presented beat does not change until it is taken.

Top module: `wideWriteStreamer`

## Requirements
- R1: After reset, `cmdReady` is 1, and `awValid`, `wValid` and `done` are 0.
- R2: A command is accepted only while `cmdReady` is high. One write-address request follows it, with `awAddr` equal to the command destination and `awLen` equal to `cmdLen` (the burst length minus one). The request stays valid and stable until `awReady` is seen.
- R3: Each 128-bit element is sent as two 64-bit beats. The first beat is bits 63:0 and the second is bits 127:64. Element k is read from scratchpad address `cmdSpAddr + k`.
- R4: At most one of `cmdReady`, `awValid` and `wValid` is high in any cycle. `wValid` rises only after the address request has been accepted.
- R5: While `wValid` is high and `wReady` is low, `wData` and `wLast` hold their values. A stall on a high-half beat never causes the low half to be presented or accepted a second time.
- R6: After the high half of every element except the last is accepted, `wValid` is low for exactly one cycle. `wValid` is not low at any other point inside the burst.
- R7: Beats after the last real element are all-zero pad beats. Exactly `cmdLen + 1` beats are accepted per command. With no stall and `cmdLen = 5`, two elements give the order low0, high0, low1, high1, zero, zero.
- R8: `wLast` is high only on the beat with index `cmdLen`. `done` is high for one cycle, in the cycle after that beat is accepted, and is low at all other times.
- R9: A command with `cmdCount = 0` produces `cmdLen + 1` zero beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command present |
| cmdReady | output | 1 | Block idle, command can be taken |
| cmdSpAddr | input | SP_AW | Scratchpad address of the first element |
| cmdDstAddr | input | DST_AW | Destination address for the burst |
| cmdCount | input | CNT_W | Number of real elements |
| cmdLen | input | LEN_W | Burst length in beats minus one |
| spRdAddr | output | SP_AW | Scratchpad read address |
| spRdData | input | ELEM_W | Scratchpad read data (combinational read) |
| awValid | output | 1 | Write-address request valid |
| awReady | input | 1 | Write-address request accepted |
| awAddr | output | DST_AW | Burst destination address |
| awLen | output | LEN_W | Burst length minus one |
| wValid | output | 1 | Write-data beat valid |
| wReady | input | 1 | Write-data beat accepted |
| wData | output | BEAT_W | Beat payload |
| wStrb | output | BEAT_W/8 | Byte strobes, all ones |
| wLast | output | 1 | Final beat of the burst |
| done | output | 1 | One-cycle pulse after the final beat |

## Verification
The properties assume the following about the inputs:
- The burst holds at least all real sub-blocks, so `cmdLen + 1 >= 2 * cmdCount`.
- The scratchpad answers a read in the same cycle with stable data.
- The ready inputs may toggle freely.

The stimulus always picks `cmdLen` no shorter than twice the element count minus one. It models the scratchpad as a combinational array that never changes. It drives both ready signals both in fixed patterns and from random draws, including a held-low stretch on a high-half beat.

// File: rtl/wws_pkg.sv
package wws_pkg;
  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_CMD  = 2'd1,
    S_DATA = 2'd2,
    S_READ = 2'd3
  } wwsState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic start;     // latch command, clear counters
    logic loadElem;  // capture scratchpad word
    logic clrSel;    // force sub-block select to zero
    logic beatFire;  // a beat was accepted
  } dpCtl_t;

  // Status from datapath to control
  typedef struct packed {
    logic lastSub;   // select points at last sub-block
    logic padMode;   // all real elements sent
    logic lastElem;  // current element is the final real one
    logic finalBeat; // current beat is the last of the burst
  } dpSts_t;
endpackage

// File: rtl/wwsCtrl.sv
module wwsCtrl
  import wws_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   cmdValid,
  input  logic   awReady,
  input  logic   wReady,
  input  dpSts_t sts,
  output logic   cmdReady,
  output logic   awValid,
  output logic   wValid,
  output logic   done,
  output dpCtl_t ctl
);
  wwsState_e state, nextState;
  logic doneQ;

  always_comb begin
    nextState = state;
    ctl = '0;
    cmdReady = 1'b0;
    awValid = 1'b0;
    wValid = 1'b0;
    case (state)
      S_IDLE: begin
        cmdReady = 1'b1;
        if (cmdValid) begin
          ctl.start = 1'b1;
          nextState = S_CMD;
        end
      end
      S_CMD: begin
        awValid = 1'b1;
        ctl.loadElem = 1'b1;
        ctl.clrSel = 1'b1;
        if (awReady) nextState = S_DATA;
      end
      S_DATA: begin
        wValid = 1'b1;
        if (wReady) begin
          ctl.beatFire = 1'b1;
          if (sts.finalBeat) nextState = S_IDLE;
          else if (sts.lastSub && !sts.padMode && !sts.lastElem) nextState = S_READ;
        end
      end
      default: begin
        ctl.loadElem = 1'b1;
        nextState = S_DATA;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      doneQ <= 1'b0;
    end else begin
      state <= nextState;
      doneQ <= (state == S_DATA) && wReady && sts.finalBeat;
    end
  end

  assign done = doneQ;
endmodule

// File: rtl/wwsDatapath.sv
module wwsDatapath
  import wws_pkg::*;
#(
  parameter int ELEM_W = 128,
  parameter int BEAT_W = 64,
  parameter int SP_AW  = 8,
  parameter int DST_AW = 32,
  parameter int CNT_W  = 8,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [SP_AW-1:0]  cmdSpAddr,
  input  logic [DST_AW-1:0] cmdDstAddr,
  input  logic [CNT_W-1:0]  cmdCount,
  input  logic [LEN_W-1:0]  cmdLen,
  input  logic [ELEM_W-1:0] spRdData,
  output logic [SP_AW-1:0]  spRdAddr,
  output logic [DST_AW-1:0] awAddr,
  output logic [LEN_W-1:0]  awLen,
  output logic [BEAT_W-1:0] wData,
  output logic              wLast,
  output dpSts_t            sts
);
  localparam int SUBS  = ELEM_W / BEAT_W;
  localparam int SEL_W = (SUBS > 1) ? $clog2(SUBS) : 1;
  localparam logic [SEL_W-1:0] LAST_SEL = SEL_W'(SUBS - 1);

  logic [SUBS-1:0][BEAT_W-1:0] elemReg;
  logic [SEL_W-1:0]  sel;
  logic [SP_AW-1:0]  rdPtr;
  logic [CNT_W-1:0]  colCnt, countReg;
  logic [LEN_W-1:0]  beatCnt, lenReg;
  logic [DST_AW-1:0] dstReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      elemReg  <= '0;
      sel      <= '0;
      rdPtr    <= '0;
      colCnt   <= '0;
      countReg <= '0;
      beatCnt  <= '0;
      lenReg   <= '0;
      dstReg   <= '0;
    end else begin
      if (ctl.start) begin
        rdPtr    <= cmdSpAddr;
        dstReg   <= cmdDstAddr;
        countReg <= cmdCount;
        lenReg   <= cmdLen;
        colCnt   <= '0;
        beatCnt  <= '0;
      end
      if (ctl.loadElem) elemReg <= spRdData;
      // every pointer moves only on an accepted beat
      if (ctl.clrSel || ctl.start) sel <= '0;
      else if (ctl.beatFire) sel <= (sel == LAST_SEL) ? '0 : sel + 1'b1;
      if (ctl.beatFire) begin
        beatCnt <= beatCnt + 1'b1;
        if (sel == LAST_SEL && !sts.padMode) begin
          colCnt <= colCnt + 1'b1;
          rdPtr  <= rdPtr + 1'b1;
        end
      end
    end
  end

  assign sts.lastSub   = (sel == LAST_SEL);
  assign sts.padMode   = (colCnt == countReg);
  assign sts.lastElem  = (colCnt == countReg - CNT_W'(1));
  assign sts.finalBeat = (beatCnt == lenReg);

  assign spRdAddr = rdPtr;
  assign awAddr   = dstReg;
  assign awLen    = lenReg;
  assign wData    = sts.padMode ? '0 : elemReg[sel];
  assign wLast    = sts.finalBeat;
endmodule

// File: rtl/wideWriteStreamer.sv
module wideWriteStreamer
  import wws_pkg::*;
#(
  parameter int ELEM_W = 128,
  parameter int BEAT_W = 64,
  parameter int SP_AW  = 8,
  parameter int DST_AW = 32,
  parameter int CNT_W  = 8,
  parameter int LEN_W  = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cmdValid,
  output logic                cmdReady,
  input  logic [SP_AW-1:0]    cmdSpAddr,
  input  logic [DST_AW-1:0]   cmdDstAddr,
  input  logic [CNT_W-1:0]    cmdCount,
  input  logic [LEN_W-1:0]    cmdLen,
  output logic [SP_AW-1:0]    spRdAddr,
  input  logic [ELEM_W-1:0]   spRdData,
  output logic                awValid,
  input  logic                awReady,
  output logic [DST_AW-1:0]   awAddr,
  output logic [LEN_W-1:0]    awLen,
  output logic                wValid,
  input  logic                wReady,
  output logic [BEAT_W-1:0]   wData,
  output logic [BEAT_W/8-1:0] wStrb,
  output logic                wLast,
  output logic                done
);
  dpCtl_t ctl;
  dpSts_t sts;

  wwsCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .awReady(awReady),
    .wReady(wReady), .sts(sts), .cmdReady(cmdReady), .awValid(awValid),
    .wValid(wValid), .done(done), .ctl(ctl)
  );

  wwsDatapath #(
    .ELEM_W(ELEM_W), .BEAT_W(BEAT_W), .SP_AW(SP_AW),
    .DST_AW(DST_AW), .CNT_W(CNT_W), .LEN_W(LEN_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cmdSpAddr(cmdSpAddr),
    .cmdDstAddr(cmdDstAddr), .cmdCount(cmdCount), .cmdLen(cmdLen),
    .spRdData(spRdData), .spRdAddr(spRdAddr), .awAddr(awAddr),
    .awLen(awLen), .wData(wData), .wLast(wLast), .sts(sts)
  );

  assign wStrb = '1;
endmodule

// File: rtl/wwsChecker.sv
module wwsChecker #(
  parameter int BEAT_W = 64,
  parameter int DST_AW = 32,
  parameter int LEN_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdReady,
  input logic              awValid,
  input logic              awReady,
  input logic [DST_AW-1:0] awAddr,
  input logic [LEN_W-1:0]  awLen,
  input logic              wValid,
  input logic              wReady,
  input logic [BEAT_W-1:0] wData,
  input logic              wLast,
  input logic              done
);
  // R5
  wdata_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    wValid && !wReady |=> wValid && $stable(wData) && $stable(wLast));
  // R2
  aw_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    awValid && !awReady |=> awValid && $stable(awAddr) && $stable(awLen));
  // R4
  phase_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmdReady, awValid, wValid}));
  // R4
  wvalid_after_aw_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wValid) |-> $past(awValid && awReady) || $past(!wValid && !awValid && !cmdReady));
  // R8
  done_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(wValid && wReady && wLast));
  // R8
  last_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    wValid && wReady && wLast |=> !wValid && done);
endmodule

bind wideWriteStreamer wwsChecker #(.BEAT_W(BEAT_W), .DST_AW(DST_AW), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rstN(rstN), .cmdReady(cmdReady), .awValid(awValid),
  .awReady(awReady), .awAddr(awAddr), .awLen(awLen), .wValid(wValid),
  .wReady(wReady), .wData(wData), .wLast(wLast), .done(done)
);

// File: tb/wideWriteStreamer_test.sv
module wideWriteStreamer_test;
  localparam int CLK_PERIOD = 10;
  localparam int ELEM_W = 128, BEAT_W = 64, SP_AW = 8, DST_AW = 32, CNT_W = 8, LEN_W = 8;

  logic clk = 1'b0, rstN = 1'b0;
  logic cmdValid = 1'b0, cmdReady;
  logic [SP_AW-1:0] cmdSpAddr = '0, spRdAddr;
  logic [DST_AW-1:0] cmdDstAddr = '0, awAddr;
  logic [CNT_W-1:0] cmdCount = '0;
  logic [LEN_W-1:0] cmdLen = '0, awLen;
  logic [ELEM_W-1:0] spRdData;
  logic awValid, awReady = 1'b0, wValid, wReady = 1'b0, wLast, done;
  logic [BEAT_W-1:0] wData;
  logic [BEAT_W/8-1:0] wStrb;

  logic [ELEM_W-1:0] spMem [0:(1<<SP_AW)-1];
  assign spRdData = spMem[spRdAddr];

  int checks = 0, errors = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wideWriteStreamer uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdSpAddr(cmdSpAddr), .cmdDstAddr(cmdDstAddr), .cmdCount(cmdCount),
    .cmdLen(cmdLen), .spRdAddr(spRdAddr), .spRdData(spRdData),
    .awValid(awValid), .awReady(awReady), .awAddr(awAddr), .awLen(awLen),
    .wValid(wValid), .wReady(wReady), .wData(wData), .wStrb(wStrb),
    .wLast(wLast), .done(done)
  );

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // expected beat i of a burst (R3, R7, R9)
  function automatic logic [BEAT_W-1:0] expBeat(int spBase, int count, int i);
    logic [ELEM_W-1:0] e;
    if (i >= 2 * count) return '0;
    e = spMem[(spBase + i / 2) % (1 << SP_AW)];
    return e[(i % 2) * BEAT_W +: BEAT_W];
  endfunction

  // mode 0: ready always high, 1: high-half stall of 3 cycles, 2: random
  task automatic runCmd(input int spBase, input int dst, input int count, input int len, input int mode);
    int beat = 0, gaps = 0, stallCnt = 0, iter = 0;
    bit prevStall = 0, prevLast = 0, doneNext = 0, awSeen = 0;
    logic [BEAT_W-1:0] prevData = '0;
    @(negedge clk);
    check(cmdReady == 1'b1, "R2 cmdReady idle", 128'(cmdReady), 1);
    cmdValid = 1'b1; cmdSpAddr = SP_AW'(spBase); cmdDstAddr = DST_AW'(dst);
    cmdCount = CNT_W'(count); cmdLen = LEN_W'(len);
    forever begin
      @(negedge clk);
      cmdValid = 1'b0;
      iter++;
      if (iter > 3000) begin
        check(0, "R7 transaction hung", 128'(beat), 128'(len + 1));
        break;
      end
      if (doneNext) begin
        check(done == 1'b1, "R8 done pulse", 128'(done), 1);
        break;
      end
      check(done == 1'b0, "R8 done quiet", 128'(done), 0);
      awReady = (mode == 2) ? 1'($urandom % 2) : 1'b1;
      if (mode == 1 && wValid && beat == 1 && stallCnt < 3) begin
        wReady = 1'b0; stallCnt++;
      end else if (mode == 2) wReady = ($urandom % 4) != 0;
      else wReady = 1'b1;
      if (prevStall) begin
        check(wValid && wData == prevData && wLast == prevLast, "R5 stable under stall",
              128'(wData), 128'(prevData));
      end
      if (awValid && awReady) begin
        check(awAddr == DST_AW'(dst) && awLen == LEN_W'(len), "R2 address request",
              {64'(awAddr), 64'(awLen)}, {64'(dst), 64'(len)});
        check(beat == 0 && !awSeen, "R4 address before data", 128'(beat), 0);
        awSeen = 1;
      end
      if (wValid) check(awSeen, "R4 data after address", 128'(awSeen), 1);
      if (wValid && wReady) begin
        check(wData == expBeat(spBase, count, beat),
              (beat < 2 * count) ? "R3 element beat" : "R7 pad beat",
              128'(wData), 128'(expBeat(spBase, count, beat)));
        check(wLast == (beat == len), "R8 last flag", 128'(wLast), 128'(beat == len));
        if (beat == len) doneNext = 1;
        beat++;
      end else if (!wValid && beat > 0) gaps++;
      prevStall = wValid && !wReady; prevData = wData; prevLast = wLast;
    end
    wReady = 1'b0; awReady = 1'b0;
    check(beat == len + 1, "R7 beat count", 128'(beat), 128'(len + 1));
    check(gaps == ((count > 0) ? count - 1 : 0), "R6 read gap cycles",
          128'(gaps), 128'((count > 0) ? count - 1 : 0));
  endtask

  initial begin
    while (1) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual %0d expected below 150000", cycles);
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int a = 0; a < (1 << SP_AW); a++) spMem[a] = {$urandom, $urandom, $urandom, $urandom};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    check(cmdReady && !awValid && !wValid && !done, "R1 reset state",
          {124'd0, cmdReady, awValid, wValid, done}, 128'h8);
    runCmd(3, 32'h1000, 2, 5, 0);     // R7 no-stall order low0 high0 low1 high1 zero zero
    runCmd(3, 32'h1000, 2, 5, 1);     // R5 high-half stall
    runCmd(40, 32'h2000, 0, 3, 0);    // R9 all pad
    runCmd(255, 32'h3000, 1, 1, 1);   // exact fit, address wrap, stall on high half
    runCmd(10, 32'h4000, 4, 7, 2);    // R6 exact fit, random ready
    for (int t = 0; t < 25; t++) begin
      int c = $urandom % 5;
      int l = ((2 * c > 0) ? 2 * c : 1) - 1 + ($urandom % 4);
      runCmd($urandom % 256, $urandom, c, l, (t % 3 == 0) ? 1 : 2);
    end
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule